// File: doc/BRIEF.md
# Automatic Black-Level Offset Calibrator

This block runs a closed-loop offset servo and a brightness trim for three 8-bit video channels. Each channel has its own black-level target code. During a reference window (the back-porch clamp interval after sync), the block adds up the difference between each incoming sample and that channel's target. When the window closes, it moves the channel's signed offset correction one step in the direction that reduces the averaged error. The correction values drive an offset DAC and clamp outside this block.

When auto mode is on, the block adds a signed 7-bit brightness trim to every pixel of each channel. The result saturates at 0 and 255. When auto mode is off, pixels pass through unchanged and the corrections are frozen. Typical targets are code 1 for RGB, and code 128 for the two colour-difference channels of component video. Any target from 1 to 254 is accepted.

Top module: `black_level_cal`

## Requirements
- R1: While rst_ni is low, every pix_o lane reads 0, every corr_o lane reads 0 and every corr_sat_o bit reads 0.
- R2: With auto_en_i low, each pix_o lane equals the pix_i lane of the previous clock edge, and trim_i has no effect.
- R3: With auto_en_i low, corr_o does not change, whatever ref_win_i and pix_i do.
- R4: With auto_en_i high, each pix_o lane equals pix_i plus that lane's trim_i one edge later. The trim is read as 7-bit two's complement, so 7'h40 is -64 and 7'h3f is +63. A trim of 0 gives pix_o equal to pix_i.
- R5: In auto mode the pixel-plus-trim sum clamps to 0 below and to 255 above, and never wraps.
- R6: At the first edge where ref_win_i is sampled low after being sampled high, each channel sums (sample - target) over the edges on which the window was high. A positive sum lowers corr_o by 1, a negative sum raises it by 1, and a zero sum leaves it unchanged. Each channel uses only its own target_i lane.
- R7: corr_o changes only on the window-closing edge of R6, and by at most one step.
- R8: corr_o is a 7-bit two's complement value held within -63..+63. A step past a limit leaves it at the limit. The lane's corr_sat_o bit is 1 exactly when the correction is at +63 or -63.
- R9: Samples presented while ref_win_i is low do not affect the correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Auto-offset mode enable |
| ref_win_i | input | 1 | Black-reference window, high during the back porch |
| pix_i | input | 24 | Three 8-bit samples, lane 0 in bits 7:0 |
| target_i | input | 24 | Three 8-bit black-level target codes |
| trim_i | input | 21 | Three 7-bit signed brightness trims, lane 0 in bits 6:0 |
| pix_o | output | 24 | Trimmed samples, registered |
| corr_o | output | 21 | Three 7-bit signed offset corrections |
| corr_sat_o | output | 3 | Per-lane flag: correction at a limit |

## Verification
Pixel results are due one edge after the sample and trim are presented, so each vector is driven, one rising edge is taken, and pix_o is read 2 ns later. A correction step is due on the single edge where a high window is first seen low. The bench holds the window for a known number of edges, drops it, and reads corr_o and corr_sat_o 2 ns after the next edge. It also reads corr_o in the middle of a window to confirm that nothing moved early. Two windows whose samples differ from the target but average to it confirm that the decision is made on the sum, not on any single sample.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/blc_trim_add.sv
module blc_trim_add #(
  parameter int DW = 8,
  parameter int TW = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 auto_en_i,
  input  logic [DW-1:0]        pix_i,
  input  logic signed [TW-1:0] trim_i,
  output logic [DW-1:0]        pix_o
);
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        sat_val;

  always_comb begin
    sum = SW'($signed({1'b0, pix_i})) + SW'(trim_i);
    if (sum < 0)         sat_val = '0;
    else if (sum > MAXV) sat_val = '1;
    else                 sat_val = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pix_o <= '0;
    else if (auto_en_i) pix_o <= sat_val;
    else                pix_o <= pix_i;
  end

  AST_MANUAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(auto_en_i)) |-> (pix_o == $past(pix_i))); // R2

  AST_ZERO_TRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(auto_en_i) && ($past(trim_i) == '0)) |-> (pix_o == $past(pix_i))); // R4
endmodule

// File: rtl/blc_servo.sv
module blc_servo
  import blc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 7,
  parameter int ACC_W = 20,
  parameter int CMAX  = 63
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 auto_en_i,
  input  logic                 win_i,
  input  logic                 win_end_i,
  input  logic [DW-1:0]        pix_i,
  input  logic [DW-1:0]        target_i,
  output logic signed [CW-1:0] corr_o,
  output logic                 sat_o
);
  logic signed [ACC_W-1:0] acc_q, err;
  logic signed [CW-1:0]    corr_q;
  step_e                   step;

  // error of one sample against the target
  assign err = ACC_W'($signed({1'b0, pix_i})) - ACC_W'($signed({1'b0, target_i}));

  always_comb begin
    if (acc_q > 0)      step = STEP_DN;
    else if (acc_q < 0) step = STEP_UP;
    else                step = STEP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      corr_q <= '0;
    end else if (!auto_en_i) begin
      acc_q  <= '0;
    end else if (win_end_i) begin
      acc_q <= '0;
      unique case (step)
        STEP_UP: if (corr_q < CMAX)  corr_q <= corr_q + CW'(1);
        STEP_DN: if (corr_q > -CMAX) corr_q <= corr_q - CW'(1);
        default: ;
      endcase
    end else if (win_i) begin
      acc_q <= acc_q + err;
    end
  end

  assign corr_o = corr_q;
  assign sat_o  = (corr_q == CW'(CMAX)) || (corr_q == CW'(-CMAX));

  AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(auto_en_i)) |-> $stable(corr_q)); // R3

  AST_STEP_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(win_end_i)) |-> $stable(corr_q)); // R7

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((corr_q == $past(corr_q)) || (corr_q == $past(corr_q) + CW'(1))
                       || (corr_q == $past(corr_q) - CW'(1)))); // R7

  AST_CORR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_q <= CMAX) && (corr_q >= -CMAX)); // R8
endmodule

// File: rtl/black_level_cal.sv
module black_level_cal #(
  parameter int NCH     = 3,
  parameter int DW      = 8,
  parameter int TW      = 7,
  parameter int CW      = 7,
  parameter int WIN_LOG = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     auto_en_i,
  input  logic                     ref_win_i,
  input  logic [NCH-1:0][DW-1:0]   pix_i,
  input  logic [NCH-1:0][DW-1:0]   target_i,
  input  logic [NCH-1:0][TW-1:0]   trim_i,
  output logic [NCH-1:0][DW-1:0]   pix_o,
  output logic [NCH-1:0][CW-1:0]   corr_o,
  output logic [NCH-1:0]           corr_sat_o
);
  localparam int ACC_W = DW + 1 + WIN_LOG;
  localparam int CMAX  = (1 << (CW - 1)) - 1;

  logic win_q, win_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= 1'b0;
    else         win_q <= ref_win_i;
  end

  assign win_end = win_q & ~ref_win_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    blc_trim_add #(.DW(DW), .TW(TW)) u_add (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .auto_en_i (auto_en_i),
      .pix_i     (pix_i[g]),
      .trim_i    (trim_i[g]),
      .pix_o     (pix_o[g])
    );

    blc_servo #(.DW(DW), .CW(CW), .ACC_W(ACC_W), .CMAX(CMAX)) u_servo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .auto_en_i (auto_en_i),
      .win_i     (ref_win_i),
      .win_end_i (win_end),
      .pix_i     (pix_i[g]),
      .target_i  (target_i[g]),
      .corr_o    (corr_o[g]),
      .sat_o     (corr_sat_o[g])
    );
  end
endmodule

// File: tb/tb_black_level_cal.sv
module tb_black_level_cal;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic auto_en = 1'b0;
  logic win = 1'b0;
  logic [2:0][7:0] pix = '0;
  logic [2:0][7:0] tgt = '0;
  logic [2:0][6:0] trim = '0;
  logic [2:0][7:0] pix_o;
  logic [2:0][6:0] corr_o;
  logic [2:0]      sat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  black_level_cal dut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_en_i(auto_en), .ref_win_i(win),
    .pix_i(pix), .target_i(tgt), .trim_i(trim),
    .pix_o(pix_o), .corr_o(corr_o), .corr_sat_o(sat_o)
  );

  // {auto, pix, trim, expected}
  localparam logic [23:0] VEC [12] = '{
    {1'b0, 8'd100, 7'h14, 8'd100},
    {1'b0, 8'd255, 7'h40, 8'd255},
    {1'b1, 8'd100, 7'h00, 8'd100},
    {1'b1, 8'd100, 7'h14, 8'd120},
    {1'b1, 8'd100, 7'h62, 8'd70},
    {1'b1, 8'd250, 7'h0a, 8'd255},
    {1'b1, 8'd255, 7'h3f, 8'd255},
    {1'b1, 8'd5,   7'h76, 8'd0},
    {1'b1, 8'd0,   7'h40, 8'd0},
    {1'b1, 8'd64,  7'h40, 8'd0},
    {1'b1, 8'd192, 7'h3f, 8'd255},
    {1'b1, 8'd128, 7'h7f, 8'd127}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_corr(input string req, input int c0, input int c1, input int c2);
    chk(req, int'($signed(corr_o[0])), c0);
    chk(req, int'($signed(corr_o[1])), c1);
    chk(req, int'($signed(corr_o[2])), c2);
  endtask

  task automatic step_clk();
    @(posedge clk);
    #2;
  endtask

  // window of n edges, samples alternate a/b, then close it
  task automatic run_win(input logic [7:0] a0, a1, a2, b0, b1, b2, input int n);
    win = 1'b1;
    for (int k = 0; k < n; k++) begin
      pix = (k % 2 == 0) ? {a2, a1, a0} : {b2, b1, b0};
      step_clk();
    end
    win = 1'b0;
    step_clk();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    pix = {8'd9, 8'd9, 8'd9};
    auto_en = 1'b1;
    win = 1'b1;
    repeat (3) step_clk();
    for (int i = 0; i < 3; i++) begin
      chk("R1 pix", int'(pix_o[i]), 0);
      chk("R1 corr", int'($signed(corr_o[i])), 0);
      chk("R1 sat", int'(sat_o[i]), 0);
    end
    win = 1'b0;
    auto_en = 1'b0;
    step_clk();
    rst_ni = 1'b1;
    step_clk();

    // R2 R4 R5 vector table
    for (int v = 0; v < 12; v++) begin
      auto_en = VEC[v][23];
      pix  = {3{VEC[v][22:15]}};
      trim = {3{VEC[v][14:8]}};
      step_clk();
      for (int i = 0; i < 3; i++)
        chk(VEC[v][23] ? "R4 R5 trim add" : "R2 pass", int'(pix_o[i]), int'(VEC[v][7:0]));
    end

    // R6 servo direction with per-channel targets
    auto_en = 1'b1;
    trim = '0;
    tgt = {8'd128, 8'd128, 8'd1};
    run_win(8'd5, 8'd128, 8'd100, 8'd5, 8'd128, 8'd100, 4);
    chk_corr("R6 first window", -1, 0, 1);

    // R7 no change mid-window, step at close
    win = 1'b1;
    pix = {8'd100, 8'd128, 8'd5};
    step_clk();
    step_clk();
    chk_corr("R7 mid-window hold", -1, 0, 1);
    win = 1'b0;
    step_clk();
    chk_corr("R7 step at close", -2, 0, 2);

    // R6 decision on the average, not single samples
    run_win(8'd0, 8'd127, 8'd100, 8'd2, 8'd129, 8'd100, 4);
    chk_corr("R6 averaged equal", -2, 0, 3);
    chk("R8 sat clear", int'(sat_o), 0);

    // R8 clamp at limits
    for (int w = 0; w < 70; w++)
      run_win(8'd5, 8'd128, 8'd100, 8'd5, 8'd128, 8'd100, 2);
    chk_corr("R8 clamp", -63, 0, 63);
    chk("R8 sat flags", int'(sat_o), 3'b101);
    run_win(8'd1, 8'd128, 8'd200, 8'd1, 8'd128, 8'd200, 2);
    chk_corr("R8 leave limit", -63, 0, 62);
    chk("R8 sat after leave", int'(sat_o), 3'b001);

    // R9 samples outside window ignored
    pix = {8'd255, 8'd0, 8'd200};
    repeat (10) step_clk();
    run_win(8'd1, 8'd128, 8'd128, 8'd1, 8'd128, 8'd128, 2);
    chk_corr("R9 outside window", -63, 0, 62);

    // R3 manual mode freezes correction
    auto_en = 1'b0;
    run_win(8'd200, 8'd200, 8'd200, 8'd200, 8'd200, 8'd200, 4);
    chk_corr("R3 manual hold", -63, 0, 62);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule